// File: doc/BRIEF.md
# Burst SRAM Read Output Stage with Bank-Safe Drive Enable

This block sits between the storage array of a synchronous burst SRAM and its shared data pins. Whenever the array presents read data for a cycle, the block registers it into a 32-bit output register. The stored word therefore appears on the pins one clock after its address was taken, and each later burst beat follows on each later clock. The block also decides, in each cycle, whether the data pins drive or float.

The drive decision comes from a four-state machine fed by the sampled chip-select terms. The select terms are an active-low chip enable, an active-high select and an active-low select. The states are `OE_OFF` (idle, floating), `OE_ARM` (just selected, still floating), `OE_ON` (driving) and `OE_TAIL` (deselected on the last edge, driving for one more cycle). The transitions are:

- `OE_OFF`→`OE_ARM` on select, and `OE_OFF`→`OE_OFF` otherwise.
- `OE_ARM`→`OE_ON` on select, and `OE_ARM`→`OE_OFF` otherwise.
- `OE_ON`→`OE_ON` on select, and `OE_ON`→`OE_TAIL` otherwise.
- `OE_TAIL`→`OE_ON` on select, and `OE_TAIL`→`OE_OFF` otherwise.

When two devices share a bus and control is handed over by toggling chip enable, the old device finishes in `OE_TAIL` while the new one waits in `OE_ARM`, so both never drive at once. A device with its selects tied active stays in `OE_ON` and adds no delay. The pin enable is the drive state ANDed with a low asynchronous output enable and with the absence of any byte write.

Top module: `sram_out_ctl`

## Requirements
- R1: The device counts as selected on a rising edge only when `ce_n`=0, `cs0`=1 and `cs1_n`=0; every other combination is a deselect.
- R2: When `rd_en` is 1 in a cycle, `dq_out` takes the value of `mem_rdata` at the next rising edge. When `rd_en` is 0, `dq_out` holds its value.
- R3: While `rst_n` is 0, `dq_oe` is 0 and `dq_out` is all zeros, and the machine rests in `OE_OFF`.
- R4: A select edge taken from `OE_OFF` leaves the pins floating for the following cycle (`OE_ARM`). Drive starts only after a second consecutive select edge.
- R5: On every edge that continues a select run, drive is held on with no gap, so a device with its selects tied active drives in every cycle after the first two edges.
- R6: A deselect edge taken from `OE_ON` keeps the pins driven for exactly one more cycle (`OE_TAIL`). A further deselect edge turns the pins off.
- R7: A select edge taken in `OE_TAIL` returns to `OE_ON` with no floating cycle.
- R8: With `oe_n`=1, `dq_oe` is 0 in that same cycle, whatever the state.
- R9: When any bit of `byte_we` is 1, `dq_oe` is 0 in that same cycle, whatever the state. Bit i stands for the byte lane holding data bits 8i+7..8i.
- R10: A deselect edge taken in `OE_ARM` returns to `OE_OFF`, and the pins never drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low, sampled on the edge |
| cs0 | input | 1 | Chip select, active high, sampled on the edge |
| cs1_n | input | 1 | Chip select, active low, sampled on the edge |
| oe_n | input | 1 | Asynchronous output enable, active low |
| byte_we | input | DATA_W/8 | Byte writes in progress, one bit per lane, active high |
| rd_en | input | 1 | Array read data is valid this cycle |
| mem_rdata | input | DATA_W | Read data from the storage array |
| dq_out | output | DATA_W | Registered read data to the pins |
| dq_oe | output | 1 | Tri-state drive enable for the data pins |

## Verification
The bench targets the handover corners of the drive machine:

- A reselect one edge after a deselect must drive without a hole. A design that went through `OE_ARM` there would float for one cycle.
- A select that lasts a single edge must never drive. A design that skipped the arming step would collide with the other bank.
- Each of the three inactive select combinations is applied on its own. A decode that ignored one term would keep driving after the tail.
- Output enable and each byte lane are raised during steady drive. A gate that was registered, or that missed one lane, would show drive in a cycle that must float.
- Read-enable gaps check that a design loading every cycle would overwrite the held burst word.

// File: rtl/sram_out_pkg.sv
package sram_out_pkg;

    // Drive-enable machine states
    typedef enum logic [1:0] {
        OE_OFF  = 2'd0,
        OE_ARM  = 2'd1,
        OE_ON   = 2'd2,
        OE_TAIL = 2'd3
    } oe_state_e;

endpackage

// File: rtl/sram_oe_fsm.sv
module sram_oe_fsm
    import sram_out_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    output logic drive_en
);

    oe_state_e state_q;
    oe_state_e state_d;

    // Next-state decision from the sampled select
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OE_OFF:  state_d = sel ? OE_ARM : OE_OFF;
            OE_ARM:  state_d = sel ? OE_ON  : OE_OFF;
            OE_ON:   state_d = sel ? OE_ON  : OE_TAIL;
            OE_TAIL: state_d = sel ? OE_ON  : OE_OFF;
            default: state_d = OE_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OE_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode: drive in steady select and in the single tail cycle
    always_comb begin
        unique case (state_q)
            OE_ON, OE_TAIL: drive_en = 1'b1;
            default:        drive_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/sram_rd_pipe.sv
module sram_rd_pipe #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] dq_out
);

    localparam int LANES = DATA_W / LANE_W;

    // One output register per byte lane, all loaded by the read strobe
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dq_out[g*LANE_W +: LANE_W] <= '0;
            end else if (rd_en) begin
                dq_out[g*LANE_W +: LANE_W] <= mem_rdata[g*LANE_W +: LANE_W];
            end
        end
    end

endmodule

// File: rtl/sram_out_ctl.sv
module sram_out_ctl #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              cs0,
    input  logic              cs1_n,
    input  logic              oe_n,
    input  logic [LANES-1:0]  byte_we,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    logic sel;
    logic drive_en;
    logic any_wr;

    // Select is true only for the one active combination of all three terms
    assign sel    = !ce_n && cs0 && !cs1_n;
    assign any_wr = |byte_we;

    sram_oe_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .drive_en (drive_en)
    );

    sram_rd_pipe #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .mem_rdata (mem_rdata),
        .dq_out    (dq_out)
    );

    // Pin enable: registered drive state gated by the asynchronous controls
    assign dq_oe = drive_en && !oe_n && !any_wr;

endmodule

// File: rtl/sram_out_ctl_chk.sv
module sram_out_ctl_chk #(
    parameter int DATA_W = 32,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              cs0,
    input logic              cs1_n,
    input logic              oe_n,
    input logic [LANES-1:0]  byte_we,
    input logic              rd_en,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe
);

    logic chk_sel;
    logic gated;
    assign chk_sel = (ce_n == 1'b0) && (cs0 == 1'b1) && (cs1_n == 1'b0);
    assign gated   = oe_n || (byte_we != '0);

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R3: assert (!dq_oe && dq_out == '0);
        end
    end

    assert_oe_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

    assert_write_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_we != '0) |-> !dq_oe);

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (dq_out == $past(mem_rdata)));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(dq_out));

    // Two deselect edges in a row always leave the pins floating (R1, R6)
    assert_idle_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_sel && !$past(chk_sel)) |=> !dq_oe);

    // Two select edges in a row after reset always drive unless gated
    assert_steady_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && chk_sel && $past(chk_sel)) |=> (dq_oe || gated));

    // Tail cycle keeps driving after leaving a select run
    assert_tail_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && !chk_sel && $past(chk_sel) && $past(chk_sel, 2))
        |=> (dq_oe || gated));

    // A lone select edge between deselects never drives
    assert_arm_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_sel && $past(chk_sel) && !$past(chk_sel, 2) && !$past(chk_sel, 3))
        |=> !dq_oe);

    // First select edge from idle floats for a cycle
    assert_arm_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_sel && !$past(chk_sel) && !$past(chk_sel, 2)) |=> !dq_oe);

endmodule

bind sram_out_ctl sram_out_ctl_chk #(
    .DATA_W (DATA_W),
    .LANES  (LANES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .cs0       (cs0),
    .cs1_n     (cs1_n),
    .oe_n      (oe_n),
    .byte_we   (byte_we),
    .rd_en     (rd_en),
    .mem_rdata (mem_rdata),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
);

// File: tb/test_sram_out_ctl.sv
module test_sram_out_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b0;
    logic        cs0 = 1'b1;
    logic        cs1_n = 1'b0;
    logic        oe_n = 1'b0;
    logic [3:0]  byte_we = 4'h0;
    logic        rd_en = 1'b0;
    logic [31:0] mem_rdata = 32'h0;
    logic [31:0] dq_out;
    logic        dq_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Reference model state
    bit          m_prev_sel = 1'b0;
    bit          m_drive = 1'b0;
    logic [31:0] m_data = 32'h0;

    always #4 clk = ~clk;

    sram_out_ctl i_sram_out_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .cs0       (cs0),
        .cs1_n     (cs1_n),
        .oe_n      (oe_n),
        .byte_we   (byte_we),
        .rd_en     (rd_en),
        .mem_rdata (mem_rdata),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input logic c_ce_n, input logic c_cs0, input logic c_cs1_n,
                       input logic c_oe_n, input logic [3:0] c_we, input logic c_rd,
                       input logic [31:0] c_d, input string tag);
        bit s;
        ce_n = c_ce_n; cs0 = c_cs0; cs1_n = c_cs1_n;
        oe_n = c_oe_n; byte_we = c_we; rd_en = c_rd; mem_rdata = c_d;
        @(posedge clk);
        s = (c_ce_n == 1'b0) && (c_cs0 == 1'b1) && (c_cs1_n == 1'b0);
        if (s) m_drive = m_prev_sel || m_drive;
        else   m_drive = m_prev_sel && m_drive;
        m_prev_sel = s;
        if (c_rd) m_data = c_d;
        @(negedge clk);
        check({tag, " oe"}, {31'd0, dq_oe},
              {31'd0, m_drive && !c_oe_n && (c_we == 4'h0)});
        check({tag, " data"}, dq_out, m_data);
    endtask

    task automatic sc(input bit s, input string tag);
        cyc(!s, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 32'h0, tag);
    endtask

    initial begin
        // R3: reset state with select driven active
        repeat (3) @(negedge clk);
        check("R3 reset oe", {31'd0, dq_oe}, 32'd0);
        check("R3 reset data", dq_out, 32'd0);
        ce_n = 1'b1;
        rst_n = 1'b1;

        // R4, R5: arm then steady drive
        sc(1, "R4 arm");
        sc(1, "R4 second select");
        sc(1, "R5 steady");
        // R6: tail then off
        sc(0, "R6 tail");
        sc(0, "R6 off");
        // R10: lone select never drives
        sc(1, "R10 arm");
        sc(0, "R10 back off");
        sc(0, "R10 idle");
        // R7: reselect during tail
        sc(1, "R7 arm");
        sc(1, "R7 on");
        sc(0, "R7 tail");
        sc(1, "R7 reselect");
        sc(1, "R7 hold");
        // R1: each inactive combination alone deselects
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 32'h0, "R1 cs0 low tail");
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 32'h0, "R1 cs0 low off");
        sc(1, "R1 arm");
        sc(1, "R1 on");
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 1'b0, 32'h0, "R1 cs1_n high tail");
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 1'b0, 32'h0, "R1 cs1_n high off");
        sc(1, "R1 arm");
        sc(1, "R1 on");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 32'h0, "R1 ce_n high tail");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 32'h0, "R1 ce_n high off");
        sc(1, "R5 arm");
        sc(1, "R5 on");
        // R2: burst of reads, then hold
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 1'b1, 32'hA5A5_0001, "R2 beat0");
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 1'b1, 32'h5A5A_0002, "R2 beat1");
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 1'b1, 32'hFFFF_0003, "R2 beat2");
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 1'b1, 32'h0000_0004, "R2 beat3");
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 32'hDEAD_BEEF, "R2 hold");
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 32'h1234_5678, "R2 hold2");
        // R8: output enable high during steady drive
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 4'h0, 1'b0, 32'h0, "R8 oe high");
        sc(1, "R8 released");
        // R9: each byte lane alone
        for (int i = 0; i < 4; i++) begin
            cyc(1'b0, 1'b1, 1'b0, 1'b0, 4'h1 << i, 1'b1, 32'h1111_1111 * (i + 1), "R9 lane write");
        end
        sc(1, "R9 released");

        // Bank-toggle and mixed pseudo-random traffic (R4 R5 R6 R7 R10)
        begin
            logic [15:0] lfsr = 16'hACE1;
            for (int k = 0; k < 400; k++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                cyc(lfsr[0], lfsr[1] | lfsr[5], lfsr[2] & lfsr[6], lfsr[3] & lfsr[7],
                    (lfsr[4] & lfsr[8]) ? lfsr[12:9] : 4'h0, lfsr[11],
                    {lfsr, ~lfsr}, "R5 R6 R7 R10 mixed");
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule